// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between a processor pipeline and its data cache. A store hands over its word address, data and byte enables and retires at once, so a cache miss on a store never holds up the pipeline. The buffered stores are then written into the cache in the background, oldest first, through a write port with a ready handshake.

Every load presents its word address and byte enables to the buffer in the same cycle as its cache access. If pending stores hit that word, the youngest of them supplies the data, and that data takes priority over whatever the cache returns. When the youngest matching store does not cover every byte the load wants, the block flags a conflict. The processor then replays the load until that store has drained. The only thing that stalls a store is a full buffer.

Top module: `store_buffer`

## Requirements
- R1: After synchronous reset the buffer is empty: `wr_valid`, `st_stall`, `ld_fwd` and `ld_conflict` are 0 and `ld_data` is zero.
- R2: A store presented while the buffer is not full is accepted on that clock edge with `st_stall` low, whether or not the cache port is ready.
- R3: While the buffer holds entries, `wr_valid` is high and the write port shows the oldest entry. Its address, data and enables hold steady until `wr_ready` is sampled high. Entries leave in the order they were stored, one per cycle while `wr_ready` stays high.
- R4: Once DEPTH (default 8) entries are pending, a presented store sees `st_stall` high and is not taken. It is accepted on the first edge after a drain has freed a slot.
- R5: A store that is accepted on the same edge as a drain leaves the occupancy unchanged. A continuous stream of stores with the cache always ready never stalls, and afterwards exactly DEPTH stores fit before a stall.
- R6: A load whose word address matches a pending store, and whose byte enables are all set in that store's enables, returns `ld_fwd`=1 in the cycle after the request. `ld_data` carries the store's bytes where `ld_be` is 1 and zeros elsewhere (byte b is bits 8b+7..8b).
- R7: When several pending stores match the load's word address, only the most recently stored one supplies the data.
- R8: When the youngest matching store lacks any byte the load enables, the result is `ld_conflict`=1, `ld_fwd`=0, `ld_data` zero. This holds even if an older match would cover the load, and it clears once that store has drained.
- R9: A load that matches no pending entry returns `ld_fwd`=0 and `ld_conflict`=0. Drained stores are not searched, and neither is a store accepted on the same edge as the load. With no load request, both flags are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte enables |
| st_stall | output | 1 | Store not taken this cycle (buffer full) |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | ADDR_W | Load word address |
| ld_be | input | DATA_W/8 | Load byte enables |
| ld_fwd | output | 1 | Registered: load data comes from the buffer |
| ld_conflict | output | 1 | Registered: partial overlap, load must replay |
| ld_data | output | DATA_W | Registered forwarded data, masked by load enables |
| wr_valid | output | 1 | Cache write request (oldest entry) |
| wr_ready | input | 1 | Cache accepts the write this cycle |
| wr_addr | output | ADDR_W | Cache write word address |
| wr_data | output | DATA_W | Cache write data |
| wr_be | output | DATA_W/8 | Cache write byte enables |

## Verification
The bench builds up three stores, two of them to the same word. A design that picks the first match rather than the last would forward stale data. A narrow younger store placed over a wide older one must raise a conflict, and a search that falls back to the older entry would return bytes that were overwritten. The bench holds a store against a full buffer and releases exactly one slot, which catches acceptance one cycle early or one cycle late as well as an overwrite of the oldest entry. It also streams stores back to back with the cache always ready and then refills the buffer to capacity. That finds an occupancy counter that drifts on simultaneous enqueue and dequeue, and a lookup that sees a store written on the same edge.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;
  // Outcome of a load lookup against the pending stores
  typedef enum logic [1:0] {
    LK_MISS     = 2'd0,
    LK_FWD      = 2'd1,
    LK_CONFLICT = 2'd2
  } lookup_e;
endpackage

// File: rtl/stbuf_ptrs.sv
module stbuf_ptrs #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enq,
  input  logic          deq,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          nonempty
);

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (enq) tail <= tail + 1'b1;
      if (deq) head <= head + 1'b1;
      case ({enq, deq})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full     = (count == CW'(DEPTH));
  assign nonempty = (count != '0);

  // R4: occupancy never exceeds the number of slots
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R5: simultaneous enqueue and dequeue keep the occupancy
  a_r5_count_hold: assert property (@(posedge clk) disable iff (rst)
    (enq && deq) |=> (count == $past(count)));

  // R3: a lone drain lowers the occupancy by exactly one
  a_r3_drain_step: assert property (@(posedge clk) disable iff (rst)
    (deq && !enq) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/stbuf_search.sv
module stbuf_search import stbuf_pkg::*; #(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int BE_W = DATA_W / 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [BE_W-1:0]   ld_be,
  input  logic [PW-1:0]     head,
  input  logic [CW-1:0]     count,
  input  logic [ADDR_W-1:0] ent_addr [DEPTH],
  input  logic [DATA_W-1:0] ent_data [DEPTH],
  input  logic [BE_W-1:0]   ent_be   [DEPTH],
  output lookup_e           result,
  output logic [DATA_W-1:0] fwd_data
);

  logic          hit;
  logic [PW-1:0] sel;
  logic [PW-1:0] idx;
  logic          covered;

  // Walk from oldest to youngest; the last match seen is the youngest.
  always_comb begin
    hit = 1'b0;
    sel = '0;
    idx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PW'(k);
      if ((CW'(k) < count) && (ent_addr[idx] == ld_addr)) begin
        hit = 1'b1;
        sel = idx;
      end
    end
  end

  assign covered = ((ent_be[sel] & ld_be) == ld_be);

  always_comb begin
    if (!ld_valid || !hit) result = LK_MISS;
    else if (covered)      result = LK_FWD;
    else                   result = LK_CONFLICT;
  end

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign fwd_data[b*8 +: 8] = (result == LK_FWD && ld_be[b]) ?
                                ent_data[sel][b*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/store_buffer.sv
module store_buffer import stbuf_pkg::*; #(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int BE_W = DATA_W / 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic [BE_W-1:0]   st_be,
  output logic              st_stall,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [BE_W-1:0]   ld_be,
  output logic              ld_fwd,
  output logic              ld_conflict,
  output logic [DATA_W-1:0] ld_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [BE_W-1:0]   wr_be
);

  // Entry storage: every slot is compared in parallel, so it stays in flops
  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [DATA_W-1:0] ent_data [DEPTH];
  logic [BE_W-1:0]   ent_be   [DEPTH];

  logic [PW-1:0] head, tail;
  logic [CW-1:0] count;
  logic          full, nonempty, enq, deq;
  lookup_e       lk_res;
  logic [DATA_W-1:0] lk_data;

  assign enq      = st_valid && !full;
  assign st_stall = st_valid && full;
  assign deq      = nonempty && wr_ready;

  stbuf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk      (clk),
    .rst      (rst),
    .enq      (enq),
    .deq      (deq),
    .head     (head),
    .tail     (tail),
    .count    (count),
    .full     (full),
    .nonempty (nonempty)
  );

  always_ff @(posedge clk) begin
    if (enq) begin
      ent_addr[tail] <= st_addr;
      ent_data[tail] <= st_data;
      ent_be[tail]   <= st_be;
    end
  end

  // Drain port presents the oldest entry
  assign wr_valid = nonempty;
  assign wr_addr  = ent_addr[head];
  assign wr_data  = ent_data[head];
  assign wr_be    = ent_be[head];

  stbuf_search #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_search (
    .ld_valid (ld_valid),
    .ld_addr  (ld_addr),
    .ld_be    (ld_be),
    .head     (head),
    .count    (count),
    .ent_addr (ent_addr),
    .ent_data (ent_data),
    .ent_be   (ent_be),
    .result   (lk_res),
    .fwd_data (lk_data)
  );

  // Lookup result registered to line up with a one-cycle cache read
  always_ff @(posedge clk) begin
    if (rst) begin
      ld_fwd      <= 1'b0;
      ld_conflict <= 1'b0;
      ld_data     <= '0;
    end else begin
      ld_fwd      <= (lk_res == LK_FWD);
      ld_conflict <= (lk_res == LK_CONFLICT);
      ld_data     <= lk_data;
    end
  end

  // R3: a write the cache has not taken stays put
  a_r3_hold_until_taken: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=>
      (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be)));

  // R8: forward and conflict never reported together
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ld_fwd && ld_conflict));

  // R9: no lookup request, no lookup result
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(ld_valid) |-> (!ld_fwd && !ld_conflict && ld_data == '0));

  // R4: a full buffer with no drain does not change what it presents
  a_r4_full_holds: assert property (@(posedge clk) disable iff (rst)
    (st_stall && !wr_ready) |=> (wr_valid && $stable(wr_addr)));

endmodule

// File: tb/store_buffer_tb.sv
module store_buffer_tb;
  localparam int AW = 30;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          st_valid = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [BW-1:0] st_be = '0;
  logic          st_stall;
  logic          ld_valid = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [BW-1:0] ld_be = '0;
  logic          ld_fwd, ld_conflict;
  logic [DW-1:0] ld_data;
  logic          wr_valid;
  logic          wr_ready = 1'b0;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [BW-1:0] wr_be;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  store_buffer #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .st_stall(st_stall),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_be(ld_be),
    .ld_fwd(ld_fwd), .ld_conflict(ld_conflict), .ld_data(ld_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be)
  );

  // Log of writes the cache accepted
  int cyc = 0;
  int lg_n = 0;
  logic [AW-1:0] lg_addr [256];
  logic [DW-1:0] lg_data [256];
  int            lg_cyc  [256];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && wr_valid && wr_ready && lg_n < 256) begin
      lg_addr[lg_n] <= wr_addr;
      lg_data[lg_n] <= wr_data;
      lg_cyc[lg_n]  <= cyc;
      lg_n <= lg_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Hold a store until taken; returns how many cycles it stalled
  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [BW-1:0] be, output int waits);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
    waits = 0;
    while (st_stall) begin
      waits++;
      @(negedge clk);
    end
    @(posedge clk);
  endtask

  task automatic st_idle();
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic lookup(input logic [AW-1:0] a, input logic [BW-1:0] be);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_be = be;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic drain_all();
    @(negedge clk);
    wr_ready = 1'b1;
    while (wr_valid) @(negedge clk);
    wr_ready = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(wr_valid == 1'b0, "R1 wr_valid after reset", 64'(wr_valid), 64'd0);
    chk(st_stall == 1'b0, "R1 st_stall after reset", 64'(st_stall), 64'd0);
    chk(ld_fwd == 1'b0 && ld_conflict == 1'b0, "R1 load flags after reset",
        64'({ld_fwd, ld_conflict}), 64'd0);
    chk(ld_data == '0, "R1 ld_data after reset", 64'(ld_data), 64'd0);
  endtask

  task automatic t_order();
    int w;
    int base;
    base = lg_n;
    for (int i = 0; i < 3; i++) begin
      push(AW'(32'h100 + i), DW'(32'hA000_0000 + i), 4'hF, w);
      chk(w == 0, "R2 store accepted without cache ready", 64'(w), 64'd0);
    end
    st_idle();
    chk(wr_valid == 1'b1, "R3 wr_valid with pending entries", 64'(wr_valid), 64'd1);
    chk(wr_addr == AW'(32'h100), "R3 oldest presented", 64'(wr_addr), 64'h100);
    repeat (3) @(negedge clk);
    chk(wr_addr == AW'(32'h100) && wr_data == DW'(32'hA000_0000),
        "R3 held while not ready", 64'(wr_data), 64'hA000_0000);
    drain_all();
    chk(lg_n - base == 3, "R3 drained count", 64'(lg_n - base), 64'd3);
    for (int i = 0; i < 3; i++) begin
      chk(lg_addr[base+i] == AW'(32'h100 + i), "R3 drain order",
          64'(lg_addr[base+i]), 64'(32'h100 + i));
    end
    chk(lg_cyc[base+2] - lg_cyc[base] == 2, "R3 one drain per cycle",
        64'(lg_cyc[base+2] - lg_cyc[base]), 64'd2);
  endtask

  task automatic t_full();
    int w;
    int base;
    base = lg_n;
    for (int i = 0; i < DEPTH; i++) begin
      push(AW'(32'h200 + i), DW'(32'hB000_0000 + i), 4'hF, w);
      chk(w == 0, "R4 fill without stall", 64'(w), 64'd0);
    end
    @(negedge clk);
    st_valid = 1'b1; st_addr = AW'(32'h2FF); st_data = DW'(32'hB0FF_0000); st_be = 4'hF;
    #1;
    chk(st_stall == 1'b1, "R4 stall when full", 64'(st_stall), 64'd1);
    repeat (3) @(negedge clk);
    chk(st_stall == 1'b1, "R4 stall persists", 64'(st_stall), 64'd1);
    wr_ready = 1'b1;
    @(negedge clk);
    wr_ready = 1'b0;
    chk(st_stall == 1'b0, "R4 slot freed", 64'(st_stall), 64'd0);
    @(negedge clk);
    st_valid = 1'b0;
    drain_all();
    chk(lg_n - base == DEPTH + 1, "R4 all stores drained",
        64'(lg_n - base), 64'(DEPTH + 1));
    chk(lg_addr[base] == AW'(32'h200), "R4 oldest survived",
        64'(lg_addr[base]), 64'h200);
    chk(lg_addr[base+DEPTH] == AW'(32'h2FF) && lg_data[base+DEPTH] == DW'(32'hB0FF_0000),
        "R4 stalled store kept and last", 64'(lg_addr[base+DEPTH]), 64'h2FF);
  endtask

  task automatic t_stream();
    int w;
    int wsum;
    int base;
    bit ord;
    base = lg_n;
    wsum = 0;
    @(negedge clk);
    wr_ready = 1'b1;
    for (int i = 0; i < 20; i++) begin
      push(AW'(32'h300 + i), DW'(32'hC000_0000 + i), 4'hF, w);
      wsum += w;
    end
    st_idle();
    chk(wsum == 0, "R5 stream never stalls", 64'(wsum), 64'd0);
    drain_all();
    chk(lg_n - base == 20, "R5 stream drained count", 64'(lg_n - base), 64'd20);
    ord = 1'b1;
    for (int i = 0; i < 20; i++)
      if (lg_addr[base+i] != AW'(32'h300 + i)) ord = 1'b0;
    chk(ord, "R5 stream order", 64'(ord), 64'd1);
    wsum = 0;
    for (int i = 0; i < DEPTH; i++) begin
      push(AW'(32'h400 + i), DW'(i), 4'hF, w);
      wsum += w;
    end
    chk(wsum == 0, "R5 exactly DEPTH fit after stream", 64'(wsum), 64'd0);
    @(negedge clk);
    st_addr = AW'(32'h4FF);
    #1;
    chk(st_stall == 1'b1, "R5 next store stalls", 64'(st_stall), 64'd1);
    st_valid = 1'b0;
    drain_all();
  endtask

  task automatic t_forward();
    int w;
    push(AW'(32'h10), 32'h1111_1111, 4'hF, w);
    push(AW'(32'h20), 32'h2222_2222, 4'hF, w);
    push(AW'(32'h10), 32'h3333_3333, 4'hF, w);
    st_idle();
    lookup(AW'(32'h10), 4'hF);
    chk(ld_fwd == 1'b1 && ld_conflict == 1'b0, "R7 youngest match forwards",
        64'({ld_fwd, ld_conflict}), 64'd2);
    chk(ld_data == 32'h3333_3333, "R7 youngest data", 64'(ld_data), 64'h3333_3333);
    lookup(AW'(32'h20), 4'b0011);
    chk(ld_fwd == 1'b1, "R6 covered load forwards", 64'(ld_fwd), 64'd1);
    chk(ld_data == 32'h0000_2222, "R6 bytes masked", 64'(ld_data), 64'h0000_2222);
    lookup(AW'(32'h30), 4'hF);
    chk(ld_fwd == 1'b0 && ld_conflict == 1'b0 && ld_data == '0, "R9 no match",
        64'({ld_fwd, ld_conflict}), 64'd0);
    push(AW'(32'h20), 32'h4444_4444, 4'b0001, w);
    st_idle();
    lookup(AW'(32'h20), 4'b0011);
    chk(ld_conflict == 1'b1 && ld_fwd == 1'b0, "R8 partial overlap conflicts",
        64'({ld_fwd, ld_conflict}), 64'd1);
    chk(ld_data == '0, "R8 no data on conflict", 64'(ld_data), 64'd0);
    lookup(AW'(32'h20), 4'b0001);
    chk(ld_fwd == 1'b1 && ld_data == 32'h0000_0044, "R6 narrow store forwards",
        64'(ld_data), 64'h44);
    drain_all();
    lookup(AW'(32'h20), 4'b0011);
    chk(ld_conflict == 1'b0 && ld_fwd == 1'b0, "R8 conflict clears after drain",
        64'({ld_fwd, ld_conflict}), 64'd0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    st_valid = 1'b1; st_addr = AW'(32'h55); st_data = 32'h5555_AAAA; st_be = 4'hF;
    ld_valid = 1'b1; ld_addr = AW'(32'h55); ld_be = 4'hF;
    @(negedge clk);
    st_valid = 1'b0; ld_valid = 1'b0;
    chk(ld_fwd == 1'b0, "R9 same-edge store not visible", 64'(ld_fwd), 64'd0);
    @(negedge clk);
    chk(ld_fwd == 1'b0 && ld_conflict == 1'b0, "R9 idle gives no result",
        64'({ld_fwd, ld_conflict}), 64'd0);
    lookup(AW'(32'h55), 4'hF);
    chk(ld_fwd == 1'b1 && ld_data == 32'h5555_AAAA, "R6 visible next cycle",
        64'(ld_data), 64'h5555_AAAA);
    drain_all();
  endtask

  initial begin
    t_reset();
    t_order();
    t_full();
    t_stream();
    t_forward();
    t_same_cycle();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule